// File: doc/BRIEF.md
# Partial Doubleword Store Unit

This unit executes the store-bytes instructions of a big-endian 64-bit datapath. From an instruction word, a base register value and a source register value, it forms the effective byte address and picks which bytes of the enclosing doubleword get written. It then presents exactly one aligned masked write request to the memory side. That request carries a doubleword address, a byte-enable vector and lane-placed write data. Begin mode stores the head fragment, running from the address to the end of its doubleword. End mode stores the tail fragment that lies just below the address. A word-sized variant applies the same rules inside one 32-bit word.

Because every fragment leaves as a single masked cycle, a fragment of 3, 5, 6 or 7 bytes can never be observed as a series of narrower stores. In end mode with an aligned address, no byte is selected. The unit then issues a probe-only cycle, which the memory side uses to check write permission and to mark the line dirty. When the modify bit is set, the request also carries the aligned base-register writeback value.

A small state machine sequences each instruction. **IDLE** accepts one instruction (op_ready high). A legal instruction takes the *accept* transition to **ISSUE**. An illegal one takes the *reject* transition to **TRAP**. **ISSUE** holds the request until req_ready, then takes the *grant* transition back to IDLE. **TRAP** raises trap for one cycle, then takes the *resume* transition back to IDLE.

Top module: `pdsu_store_unit`

## Requirements
- R1: The instruction is recognised only when bits [31:26] = 000011 and bit 12 = 1, and bits [9:6] = 1101 (doubleword form) or 1100 (word form). Bit 13 selects end mode (1) or begin mode (0), bit 5 is the modify bit, and bits [4:0] hold a two's-complement displacement added to op_base. Any other word is rejected: the unit goes to TRAP, trap is high for one cycle, and no request is issued.
- R2: Doubleword begin mode with k = address[2:0] enables lanes k..7 (lane 0 is the lowest address, enabled by req_be bit 7). It writes the least-significant 8−k bytes of the value there, so k = 0 enables all eight lanes.
- R3: Doubleword end mode enables lanes 0..k−1 and writes the most-significant k bytes of the value there.
- R4: End mode with a zero offset (k = 0, or a word offset of 0 in word form) issues a request with req_be = 0 and req_probe = 1. Every other request has req_probe = 0.
- R5: Each instruction produces exactly one request, and its enabled lanes form one contiguous run.
- R6: req_addr is the effective address with bits [2:0] cleared. Data bytes of lanes that are not enabled are zero.
- R7: With the modify bit set, req_wb_en = 1 and req_wb_addr is the effective address with its low three bits cleared (doubleword form) or low two bits cleared (word form). Otherwise req_wb_en = 0.
- R8: The doubleword form with mode64 = 0 is rejected as in R1, with no request.
- R9: The word form uses address[1:0] as the offset within the word that address[2] selects (address[2] = 0 selects lanes 0..3). It places bytes from the value's low 32 bits, most-significant first, exactly as R2/R3 do for a 4-byte unit.
- R10: While req_valid is high and req_ready is low, all request outputs stay stable. op_ready is high only in IDLE.
- R11: After reset, op_ready = 1 and req_valid = 0, trap = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Instruction offered |
| op_ready | output | 1 | Unit can take an instruction |
| op_insn | input | 32 | Instruction word |
| op_base | input | ADDR_W | Base register value |
| op_value | input | 8*LANES | Source register value |
| mode64 | input | 1 | 64-bit architecture mode |
| req_valid | output | 1 | Memory request pending |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | ADDR_W | Doubleword-aligned address |
| req_be | output | LANES | Byte enables, MSB = lowest address lane |
| req_data | output | 8*LANES | Lane-placed write data |
| req_probe | output | 1 | Permission probe only, no bytes |
| req_wb_en | output | 1 | Base register writeback requested |
| req_wb_addr | output | ADDR_W | Writeback value |
| trap | output | 1 | Illegal-instruction pulse |

## Verification
The assertions assume that the memory side only raises req_ready as an acceptance of a pending request. They also assume that op_insn, op_base and op_value matter only in the cycle when op_valid and op_ready are both high. The stimulus drives instructions for a single cycle at the falling edge while the unit is in IDLE. It keeps req_ready low until the bench has sampled the pending request, including a deliberate multi-cycle stall.

// File: rtl/pdsu_pkg.sv
package pdsu_pkg;
    localparam logic [5:0] OPC_MAJOR = 6'b000011;
    localparam logic [3:0] EXT_DWORD = 4'b1101;
    localparam logic [3:0] EXT_WORD  = 4'b1100;
    localparam int         IMM_W     = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_TRAP  = 2'd2
    } pdsu_state_e;

    typedef struct packed {
        logic             legal;
        logic             is_word;
        logic             end_mode;
        logic             modify;
        logic [IMM_W-1:0] imm;
    } pdsu_dec_t;
endpackage

// File: rtl/pdsu_decode.sv
module pdsu_decode
    import pdsu_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        mode64,
    output pdsu_dec_t   dec
);
    logic fmt_ok, is_dw, is_w;

    always_comb begin
        fmt_ok       = (insn[31:26] == OPC_MAJOR) && insn[12];
        is_dw        = (insn[9:6] == EXT_DWORD);
        is_w         = (insn[9:6] == EXT_WORD);
        dec.legal    = fmt_ok && (is_w || (is_dw && mode64));
        dec.is_word  = is_w;
        dec.end_mode = insn[13];
        dec.modify   = insn[5];
        dec.imm      = insn[IMM_W-1:0];
    end
endmodule

// File: rtl/pdsu_lanes.sv
module pdsu_lanes #(
    parameter int LANES = 8
) (
    input  logic                     is_word,
    input  logic                     end_mode,
    input  logic [$clog2(LANES)-1:0] addr_lo,
    input  logic [8*LANES-1:0]       value,
    output logic [LANES-1:0]         be,
    output logic [8*LANES-1:0]       data,
    output logic                     probe
);
    localparam int OFF_W  = $clog2(LANES);
    localparam int DATA_W = 8 * LANES;
    localparam int HALF   = LANES / 2;

    logic [OFF_W-1:0] off;
    assign off   = is_word ? {1'b0, addr_lo[OFF_W-2:0]} : addr_lo;
    assign probe = end_mode && (off == '0);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE = OFF_W'(j);
        logic             in_half, en;
        logic [OFF_W-1:0] pos;
        logic [7:0]       src;

        assign in_half = is_word ? (LANE[OFF_W-1] == addr_lo[OFF_W-1]) : 1'b1;
        assign pos     = is_word ? {1'b0, LANE[OFF_W-2:0]} : LANE;
        assign en      = in_half && (end_mode ? (pos < off) : (pos >= off));
        assign src     = is_word ? value[DATA_W/2-1-8*(j%HALF) -: 8]
                                 : value[DATA_W-1-8*j -: 8];
        assign be[LANES-1-j]          = en;
        assign data[DATA_W-1-8*j -: 8] = en ? src : 8'h00;
    end
endmodule

// File: rtl/pdsu_store_unit.sv
module pdsu_store_unit
    import pdsu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LANES  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    output logic                  op_ready,
    input  logic [31:0]           op_insn,
    input  logic [ADDR_W-1:0]     op_base,
    input  logic [8*LANES-1:0]    op_value,
    input  logic                  mode64,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [ADDR_W-1:0]     req_addr,
    output logic [LANES-1:0]      req_be,
    output logic [8*LANES-1:0]    req_data,
    output logic                  req_probe,
    output logic                  req_wb_en,
    output logic [ADDR_W-1:0]     req_wb_addr,
    output logic                  trap
);
    localparam int OFF_W  = $clog2(LANES);
    localparam int DATA_W = 8 * LANES;

    pdsu_state_e state_q, state_d;
    pdsu_dec_t   dec;
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] data_c;
    logic              probe_c, accept;

    pdsu_decode u_decode (
        .insn   (op_insn),
        .mode64 (mode64),
        .dec    (dec)
    );

    assign ea     = op_base + {{(ADDR_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
    assign accept = op_valid && (state_q == ST_IDLE);

    pdsu_lanes #(.LANES(LANES)) u_lanes (
        .is_word  (dec.is_word),
        .end_mode (dec.end_mode),
        .addr_lo  (ea[OFF_W-1:0]),
        .value    (op_value),
        .be       (be_c),
        .data     (data_c),
        .probe    (probe_c)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (op_valid) state_d = dec.legal ? ST_ISSUE : ST_TRAP;
            ST_ISSUE: if (req_ready) state_d = ST_IDLE;
            ST_TRAP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request payload, captured on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr    <= '0;
            req_be      <= '0;
            req_data    <= '0;
            req_probe   <= 1'b0;
            req_wb_en   <= 1'b0;
            req_wb_addr <= '0;
        end else if (accept && dec.legal) begin
            req_addr    <= {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            req_be      <= be_c;
            req_data    <= data_c;
            req_probe   <= probe_c;
            req_wb_en   <= dec.modify;
            req_wb_addr <= dec.is_word ? {ea[ADDR_W-1:OFF_W-1], {(OFF_W-1){1'b0}}}
                                       : {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end

    // outputs
    always_comb begin
        op_ready  = 1'b0;
        req_valid = 1'b0;
        trap      = 1'b0;
        unique case (state_q)
            ST_IDLE:  op_ready  = 1'b1;
            ST_ISSUE: req_valid = 1'b1;
            ST_TRAP:  trap      = 1'b1;
            default:  ;
        endcase
    end

    logic [LANES+1:0] be_pad;
    assign be_pad = {1'b0, req_be, 1'b0};

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_be)
            && $stable(req_data) && $stable(req_probe) && $stable(req_wb_addr))) else $error("hold"); // R10
    AST_ONE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_probe) |-> ($countones(be_pad ^ (be_pad >> 1)) == 2)) else $error("run"); // R5
    AST_PROBE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe) |-> (req_be == '0)) else $error("probe"); // R4
    AST_TRAP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!req_valid && !op_ready)) else $error("trap"); // R1
    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap) else $error("pulse"); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !op_ready) else $error("ready"); // R10
endmodule

// File: tb/pdsu_store_unit_bench.sv
module pdsu_store_unit_bench;
    localparam int N = 10;

    typedef struct packed {
        logic        word;
        logic        endm;
        logic        modify;
        logic [63:0] base;
        logic [4:0]  imm;
        logic [7:0]  be;
        logic        probe;
    } vec_t;

    localparam vec_t VEC [N] = '{
        '{1'b0, 1'b0, 1'b1, 64'h1000, 5'd3,  8'h1F, 1'b0}, // R2 k=3
        '{1'b0, 1'b1, 1'b0, 64'h1000, 5'd5,  8'hF8, 1'b0}, // R3 k=5
        '{1'b0, 1'b1, 1'b1, 64'h1008, 5'd0,  8'h00, 1'b1}, // R4 k=0
        '{1'b0, 1'b0, 1'b0, 64'h1008, 5'd0,  8'hFF, 1'b0}, // R2 k=0
        '{1'b0, 1'b0, 1'b1, 64'h1010, 5'h1F, 8'h01, 1'b0}, // R2 k=7, negative disp
        '{1'b0, 1'b1, 1'b0, 64'h1000, 5'd7,  8'hFE, 1'b0}, // R3 k=7
        '{1'b1, 1'b0, 1'b1, 64'h1000, 5'd1,  8'h70, 1'b0}, // R9 begin
        '{1'b1, 1'b1, 1'b1, 64'h1000, 5'd6,  8'h0C, 1'b0}, // R9 end upper word
        '{1'b1, 1'b1, 1'b0, 64'h1000, 5'd4,  8'h00, 1'b1}, // R4 word probe
        '{1'b0, 1'b0, 1'b0, 64'h2000, 5'd6,  8'h03, 1'b0}  // R2 k=6
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        op_valid = 1'b0, req_ready = 1'b0, mode64 = 1'b1;
    logic [31:0] op_insn = '0;
    logic [63:0] op_base = '0, op_value = 64'h0102030405060708;
    logic        op_ready, req_valid, req_probe, req_wb_en, trap;
    logic [63:0] req_addr, req_data, req_wb_addr;
    logic [7:0]  req_be;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    pdsu_store_unit u_pdsu_store_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_insn(op_insn), .op_base(op_base), .op_value(op_value), .mode64(mode64),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_be(req_be), .req_data(req_data), .req_probe(req_probe),
        .req_wb_en(req_wb_en), .req_wb_addr(req_wb_addr), .trap(trap)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(logic [5:0] maj, logic [3:0] ext,
                                        logic endm, logic modify, logic [4:0] imm);
        return {maj, 5'd2, 5'd3, 2'b00, endm, 1'b1, 2'b00, ext, modify, imm};
    endfunction

    // lane model: lane j (lowest address first) is enabled by be[7-j]
    function automatic logic [63:0] model_data(logic [7:0] be, logic word, logic [63:0] v);
        logic [63:0] d = '0;
        for (int j = 0; j < 8; j++)
            if (be[7-j])
                d[63-8*j -: 8] = word ? v[31-8*(j%4) -: 8] : v[63-8*j -: 8];
        return d;
    endfunction

    task automatic issue(logic [31:0] insn, logic [63:0] base);
        @(negedge clk);
        op_valid = 1'b1; op_insn = insn; op_base = base;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic grant();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        check("R11 op_ready", {63'b0, op_ready}, 64'd1);
        check("R11 req_valid", {63'b0, req_valid}, 64'd0);
        check("R11 trap", {63'b0, trap}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            logic [63:0] ea;
            ea = VEC[i].base + {{59{VEC[i].imm[4]}}, VEC[i].imm};
            issue(enc(6'b000011, VEC[i].word ? 4'b1100 : 4'b1101,
                      VEC[i].endm, VEC[i].modify, VEC[i].imm), VEC[i].base);
            check("R5 req_valid", {63'b0, req_valid}, 64'd1);
            check("R2 R3 R9 req_be", {56'b0, req_be}, {56'b0, VEC[i].be});
            check("R4 req_probe", {63'b0, req_probe}, {63'b0, VEC[i].probe});
            check("R6 req_addr", req_addr, ea & ~64'h7);
            check("R6 req_data", req_data, model_data(VEC[i].be, VEC[i].word, op_value));
            check("R7 req_wb_en", {63'b0, req_wb_en}, {63'b0, VEC[i].modify});
            if (VEC[i].modify)
                check("R7 req_wb_addr", req_wb_addr, ea & (VEC[i].word ? ~64'h3 : ~64'h7));
            grant();
            check("R5 single request", {63'b0, req_valid}, 64'd0);
        end

        // R10: stall holds the request
        issue(enc(6'b000011, 4'b1101, 1'b0, 1'b0, 5'd2), 64'h3000);
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check("R10 held valid", {63'b0, req_valid}, 64'd1);
            check("R10 held be", {56'b0, req_be}, 64'h3F);
            check("R10 op_ready low", {63'b0, op_ready}, 64'd0);
        end
        grant();
        check("R10 op_ready back", {63'b0, op_ready}, 64'd1);

        // R8: doubleword form in 32-bit mode
        mode64 = 1'b0;
        issue(enc(6'b000011, 4'b1101, 1'b0, 1'b1, 5'd1), 64'h1000);
        check("R8 trap", {63'b0, trap}, 64'd1);
        check("R8 no request", {63'b0, req_valid}, 64'd0);
        @(negedge clk);
        check("R8 trap pulse ends", {63'b0, trap}, 64'd0);
        // R9: word form legal in 32-bit mode
        issue(enc(6'b000011, 4'b1100, 1'b0, 1'b0, 5'd0), 64'h1004);
        check("R9 word in 32-bit mode", {56'b0, req_be}, 64'h0F);
        check("R9 word data", req_data, 64'h0000000005060708);
        grant();
        mode64 = 1'b1;

        // R1: wrong major opcode, wrong extension, bit 12 clear
        issue(enc(6'b000010, 4'b1101, 1'b0, 1'b0, 5'd0), 64'h1000);
        check("R1 bad major", {62'b0, trap, req_valid}, 64'd2);
        issue(enc(6'b000011, 4'b1110, 1'b0, 1'b0, 5'd0), 64'h1000);
        check("R1 bad ext", {62'b0, trap, req_valid}, 64'd2);
        issue(enc(6'b000011, 4'b1101, 1'b0, 1'b0, 5'd0) & ~32'h1000, 64'h1000);
        check("R1 bit12 clear", {62'b0, trap, req_valid}, 64'd2);
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule